// File: doc/BRIEF.md
# Tagged Lock Acquisition Sequencer

This block obtains a shared lock word in memory on behalf of one client. The client pulses a request strobe together with a nonzero owner tag. The sequencer then polls the lock word with plain reads until it finds it free, which means all zeros. It then issues one atomic exchange that writes the owner tag and returns the previous contents. The block grants the lock only when that returned value is zero. Nothing is assumed from the exchange alone.

If another client slipped in between the free read and the exchange, the returned value is that client's tag. The exchange has just overwritten it, so the sequencer writes the returned value back, counts a retry and returns to polling. Each failed poll or failed exchange counts as one retry. When the retry budget runs out, the block reports an error instead of carrying on. While the lock is held, a release pulse writes zero to the lock word with a plain write.

The memory port connects straight to an atomic memory unit with no cache in between. Atomicity comes only from that unit.

Top module: `sem_acquire_seq`

## Requirements
- R1: After reset, `busy_o`, `granted_o`, `error_o` and `mem_req_o` are all low.
- R2: A request strobe with `tag_i` equal to zero, while not busy and not granted, puts the block in the error state. `error_o` is high from the cycle after the strobe is sampled, and no memory access is issued.
- R3: An accepted request starts polling with plain reads (`mem_op_o` = 0). Polling continues until a read returns zero, the unassigned value.
- R4: After a zero read, the block issues an atomic exchange (`mem_op_o` = 2) with `mem_wdata_o` equal to the owner tag. It enters the granted state only if the exchange returns zero.
- R5: If the exchange returns a nonzero value, the block writes that value back with a plain write (`mem_op_o` = 1) before polling again.
- R6: After a failed poll or a restore write, `mem_req_o` stays low for exactly `poll_gap_i` + 1 cycles before the next read request.
- R7: With `MAX_RETRY` = N, failure number N+1 puts the block in the error state. A new request with a nonzero tag leaves the error state and starts a fresh acquisition.
- R8: `rel_i` while granted issues a plain write of zero and then returns to idle. `rel_i` in any other state has no effect.
- R9: A request strobe while busy or granted is ignored. The tag in use does not change and no error is raised.
- R10: A memory request holds its operation and write data steady until `mem_ack_i` is seen. `mem_req_o` drops in the cycle after the acknowledge. `busy_o` is high for the whole acquisition and release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Acquisition request strobe |
| tag_i | input | TAG_W | Owner tag for the request, nonzero |
| rel_i | input | 1 | Release strobe |
| poll_gap_i | input | GAP_W | Idle cycles between polls, minus one |
| busy_o | output | 1 | Acquisition or release in progress |
| granted_o | output | 1 | Lock held by this client |
| error_o | output | 1 | Zero tag or retry budget exhausted |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_op_o | output | 2 | 0 read, 1 write, 2 atomic exchange |
| mem_wdata_o | output | TAG_W | Write or exchange data |
| mem_ack_i | input | 1 | One-cycle acknowledge from memory |
| mem_rdata_i | input | TAG_W | Old value of the lock word, valid with the acknowledge |

## Verification
All status outputs come straight from the state register. A strobe sampled at one edge therefore shows on `busy_o` or `error_o` after that edge. An acknowledge sampled at one edge changes `mem_req_o`, `mem_op_o` and `granted_o` after that same edge. The bench memory acknowledges one cycle after it sees a new request. A behavioural model advances on the same edge from the same sampled inputs. All outputs are compared at the falling edge, half a cycle after the edge that produced them. The gap length is measured by counting falling edges with the request low, starting after the failing acknowledge.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_WAIT, ST_SWAP, ST_UNDO, ST_HELD, ST_FREE, ST_FAULT
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_XCHG  = 2'd2
  } mem_op_t;
endpackage

// File: rtl/sem_gap_timer.sv
module sem_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] val,
  input  logic             run,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sem_retry_ctr.sv
module sem_retry_ctr #(
  parameter int MAX_RETRY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == RW'(MAX_RETRY));
endmodule

// File: rtl/sem_acquire_seq.sv
module sem_acquire_seq
  import sem_pkg::*;
#(
  parameter int TAG_W     = 8,
  parameter int GAP_W     = 4,
  parameter int MAX_RETRY = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             rel_i,
  input  logic [GAP_W-1:0] poll_gap_i,
  output logic             busy_o,
  output logic             granted_o,
  output logic             error_o,
  output logic             mem_req_o,
  output logic [1:0]       mem_op_o,
  output logic [TAG_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [TAG_W-1:0] mem_rdata_i
);
  localparam logic [TAG_W-1:0] FREE_VAL = '0;

  seq_state_t       state_q, state_d;
  logic [TAG_W-1:0] tag_q, undo_q;
  logic             start, fail, at_limit, gap_done;
  logic             rd_free;
  mem_op_t          op_c;

  assign rd_free = (mem_rdata_i == FREE_VAL);
  assign start   = req_i && (state_q == ST_IDLE || state_q == ST_FAULT) && (tag_i != FREE_VAL);
  assign fail    = mem_ack_i && ((state_q == ST_POLL && !rd_free) || state_q == ST_UNDO);

  sem_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst(rst), .clr(start), .inc(fail && !at_limit), .at_limit(at_limit)
  );

  sem_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .load(fail), .val(poll_gap_i),
    .run(state_q == ST_WAIT), .expired(gap_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_FAULT:
        if (req_i) state_d = (tag_i == FREE_VAL) ? ST_FAULT : ST_POLL;
      ST_POLL:
        if (mem_ack_i) begin
          if (rd_free)       state_d = ST_SWAP;
          else if (at_limit) state_d = ST_FAULT;
          else               state_d = ST_WAIT;
        end
      ST_WAIT:
        if (gap_done) state_d = ST_POLL;
      ST_SWAP:
        if (mem_ack_i) state_d = rd_free ? ST_HELD : ST_UNDO;
      ST_UNDO:
        if (mem_ack_i) state_d = at_limit ? ST_FAULT : ST_WAIT;
      ST_HELD:
        if (rel_i) state_d = ST_FREE;
      ST_FREE:
        if (mem_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      undo_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start) tag_q <= tag_i;
      if (state_q == ST_SWAP && mem_ack_i && !rd_free) undo_q <= mem_rdata_i;
    end
  end

  always_comb begin
    op_c = OP_READ;
    mem_wdata_o = FREE_VAL;
    unique case (state_q)
      ST_SWAP: begin op_c = OP_XCHG;  mem_wdata_o = tag_q;  end
      ST_UNDO: begin op_c = OP_WRITE; mem_wdata_o = undo_q; end
      ST_FREE: begin op_c = OP_WRITE; mem_wdata_o = FREE_VAL; end
      default: ;
    endcase
  end

  assign mem_op_o  = op_c;
  assign mem_req_o = (state_q == ST_POLL) || (state_q == ST_SWAP) ||
                     (state_q == ST_UNDO) || (state_q == ST_FREE);
  assign busy_o    = mem_req_o || (state_q == ST_WAIT);
  assign granted_o = (state_q == ST_HELD);
  assign error_o   = (state_q == ST_FAULT);
endmodule

// File: rtl/sem_acquire_chk.sv
module sem_acquire_chk #(
  parameter int TAG_W = 8,
  parameter int GAP_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_i,
  input logic [TAG_W-1:0] tag_i,
  input logic             rel_i,
  input logic [GAP_W-1:0] poll_gap_i,
  input logic             busy_o,
  input logic             granted_o,
  input logic             error_o,
  input logic             mem_req_o,
  input logic [1:0]       mem_op_o,
  input logic [TAG_W-1:0] mem_wdata_o,
  input logic             mem_ack_i,
  input logic [TAG_W-1:0] mem_rdata_i
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_op_o) && $stable(mem_wdata_o)); // R10

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o); // R10

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_o, granted_o, error_o})); // R9

  AST_XCHG_TAG: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_op_o == 2'd2 |-> mem_wdata_o != '0); // R4

  AST_GRANT_FROM_FREE: assert property (@(posedge clk) disable iff (rst)
    $rose(granted_o) |-> $past(mem_ack_i && mem_op_o == 2'd2 && mem_rdata_i == '0)); // R4

  AST_ZERO_TAG: assert property (@(posedge clk) disable iff (rst)
    req_i && tag_i == '0 && !busy_o && !granted_o |=> error_o && !mem_req_o); // R2

  AST_RELEASE_WRITE: assert property (@(posedge clk) disable iff (rst)
    granted_o && rel_i |=> mem_req_o && mem_op_o == 2'd1 && mem_wdata_o == '0); // R8

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy_o && !mem_req_o && poll_gap_i != '0 |-> !mem_ack_i); // R6
endmodule

bind sem_acquire_seq sem_acquire_chk #(.TAG_W(TAG_W), .GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .tag_i(tag_i), .rel_i(rel_i),
  .poll_gap_i(poll_gap_i), .busy_o(busy_o), .granted_o(granted_o),
  .error_o(error_o), .mem_req_o(mem_req_o), .mem_op_o(mem_op_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
);

// File: tb/test_sem_acquire_seq.sv
`timescale 1ns/1ps
module test_sem_acquire_seq;
  localparam int TW = 8, GW = 4, MR = 3;
  localparam logic [TW-1:0] OTHER = 8'hA7;

  logic clk = 0, rst = 1;
  logic req = 0, rel = 0;
  logic [TW-1:0] tag = 0;
  logic [GW-1:0] gap = 0;
  logic busy, granted, error, mreq, ack;
  logic [1:0] mop;
  logic [TW-1:0] wdata, rdata, lockw;
  logic set_req = 0, steal = 0, steal_clr;
  logic [TW-1:0] set_val = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sem_acquire_seq #(.TAG_W(TW), .GAP_W(GW), .MAX_RETRY(MR)) i_sem_acquire_seq (
    .clk(clk), .rst(rst), .req_i(req), .tag_i(tag), .rel_i(rel), .poll_gap_i(gap),
    .busy_o(busy), .granted_o(granted), .error_o(error), .mem_req_o(mreq),
    .mem_op_o(mop), .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_rdata_i(rdata));

  // atomic memory: acknowledges one cycle after a new request
  always @(posedge clk) begin
    steal_clr <= 0;
    if (rst) begin ack <= 0; lockw <= 0; rdata <= 0; end
    else begin
      if (set_req) lockw <= set_val;
      if (mreq && !ack) begin
        ack <= 1;
        case (mop)
          2'd0: rdata <= lockw;
          2'd1: begin rdata <= lockw; lockw <= wdata; end
          default: begin rdata <= steal ? OTHER : lockw; lockw <= wdata; steal_clr <= steal; end
        endcase
      end else ack <= 0;
    end
  end
  always @(negedge clk) if (steal_clr) steal <= 0;

  // behavioural reference: phase 0 idle,1 read,2 gap,3 xchg,4 restore,5 held,6 release,7 error
  int ph, fcnt, gcnt;
  logic [TW-1:0] mtag, mundo;
  always @(posedge clk) begin
    if (rst) begin ph <= 0; fcnt <= 0; gcnt <= 0; mtag <= 0; mundo <= 0; end
    else case (ph)
      0, 7: if (req) begin
        if (tag == 0) ph <= 7;
        else begin mtag <= tag; fcnt <= 0; ph <= 1; end
      end
      1: if (ack) begin
        if (rdata == 0) ph <= 3;
        else if (fcnt == MR) ph <= 7;
        else begin fcnt <= fcnt + 1; gcnt <= int'(gap); ph <= 2; end
      end
      2: if (gcnt == 0) ph <= 1; else gcnt <= gcnt - 1;
      3: if (ack) begin
        if (rdata == 0) ph <= 5; else begin mundo <= rdata; ph <= 4; end
      end
      4: if (ack) begin
        if (fcnt == MR) ph <= 7;
        else begin fcnt <= fcnt + 1; gcnt <= int'(gap); ph <= 2; end
      end
      5: if (rel) ph <= 6;
      6: if (ack) ph <= 0;
      default: ph <= 0;
    endcase
  end

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    logic eb, er;
    int eop, ewd;
    eb = (ph inside {1, 2, 3, 4, 6});
    er = (ph inside {1, 3, 4, 6});
    eop = (ph == 3) ? 2 : (ph == 4 || ph == 6) ? 1 : 0;
    ewd = (ph == 3) ? int'(mtag) : (ph == 4) ? int'(mundo) : 0;
    check("model R10 status", {busy, granted, error, mreq}, {eb, ph == 5, ph == 7, er});
    if (er) check("model R3/R4/R5 op+data", {mop, wdata}, {eop[1:0], ewd[TW-1:0]});
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_req(input logic [TW-1:0] t);
    req = 1; tag = t; @(negedge clk); req = 0;
  endtask
  task automatic pulse_rel; rel = 1; @(negedge clk); rel = 0; endtask
  task automatic poke(input logic [TW-1:0] v);
    set_req = 1; set_val = v; @(negedge clk); set_req = 0;
  endtask
  task automatic wait_for(input int which);
    while (!((which == 0 && granted) || (which == 1 && error) || (which == 2 && !busy)))
      @(negedge clk);
  endtask
  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    finish_run();
  end

  initial begin
    int q;
    cyc(3); rst = 0; @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {busy, granted, error, mreq}, 0);

    // R8 release while idle ignored
    poke(8'h33); pulse_rel(); cyc(3);
    check("R8 release idle ignored lock", lockw, 8'h33);
    check("R8 release idle no busy", busy, 0);
    poke(0);

    // R2 zero tag
    pulse_req(0);
    check("R2 zero tag error", error, 1);
    check("R2 zero tag no access", mreq, 0);

    // R3 R4 free lock acquisition, also leaves error (R7)
    gap = 2; pulse_req(8'h11);
    check("R7 new request clears error", error, 0);
    wait_for(0);
    check("R4 lock holds tag", lockw, 8'h11);
    // R9 request while granted ignored
    pulse_req(0); cyc(2);
    check("R9 req while granted no error", {granted, error}, 2'b10);
    // R8 release
    pulse_rel(); wait_for(2);
    check("R8 release wrote zero", lockw, 0);
    check("R8 back to idle", {busy, granted}, 0);

    // R6 gap measurement, lock held by another owner
    poke(OTHER); gap = 3; pulse_req(8'h22);
    while (!(ack && mreq)) @(negedge clk);
    @(negedge clk); q = 0;
    while (!mreq) begin q++; @(negedge clk); end
    check("R6 idle cycles between polls", q, 4);
    poke(0); wait_for(0);
    check("R3 acquired after holder left", lockw, 8'h22);
    pulse_rel(); wait_for(2);

    // R7 retry limit
    poke(OTHER); gap = 0; pulse_req(8'h44); wait_for(1);
    check("R7 error after limit", error, 1);
    check("R7 lock untouched", lockw, OTHER);
    poke(0); pulse_req(8'h45); wait_for(0);
    check("R7 restart after error", lockw, 8'h45);
    pulse_rel(); wait_for(2);

    // R5 lost race on exchange, R9 request ignored while busy
    steal = 1; gap = 1; pulse_req(8'h66);
    pulse_req(8'h55);
    while (!(ack && mreq && mop == 2'd1)) @(negedge clk);
    check("R5 restored other owner", lockw, OTHER);
    poke(0); wait_for(0);
    check("R9 tag kept while busy", lockw, 8'h66);
    pulse_rel(); wait_for(2);
    check("R8 final release", lockw, 0);
    cyc(2);
    finish_run();
  end
endmodule